// File: doc/BRIEF.md
# Staged Transmit Buffer with Commit

This block is the transmit side of a high-speed serial port's host interface. The host places outgoing bytes into a 1024-byte memory window. Staging a byte does not hand it to the transmitter. Only when the host writes a byte count to the transmit control register does that many staged bytes become committed. Committed bytes then leave one per accepted handshake on a byte-wide ready/valid output, which stands in for the serial shifter.

Window addresses are relative to the current write pointer, so the host always stages a block starting at the window start. A read of the transmit control register returns the committed fill count and the write pointer. A space-available output tells the host when the fill level has fallen to a programmable threshold, so that it can refill the buffer.

Top module: `txwin_buf`

## Requirements
- R1: After reset the fill count and the write pointer are 0, `tx_valid` is low, `space_avail` is high, and the trigger code reads back as 5.
- R2: A byte written to window address 0x400+k lands in storage at (write pointer + k) mod 1024. Committed bytes therefore leave in ascending offset order, whatever order they were written in.
- R3: Staged bytes that have not been committed never appear on `tx_valid`/`tx_data`, and they do not change the fill count or the write pointer.
- R4: A write of N (taken from `bus_wdata[9:0]`) to address 0x804 advances the write pointer by N mod 1024 and adds N to the fill count. The host keeps the fill count at or below 1020.
- R5: A read of address 0x804 returns the fill count in bits [25:16] and the write pointer in bits [9:0], with all other bits 0. The value appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds until the next read.
- R6: Each cycle with `tx_valid` and `tx_ready` both high removes one byte and lowers the fill count by one. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R7: The trigger code n is written and read in bits [18:16] of address 0x808. `space_avail` is high exactly while the fill count is at or below 2^(n+2).
- R8: `tx_valid` is high exactly when the fill count is not 0.
- R9: The write and read positions wrap from 1023 to 0 without losing or reordering bytes.
- R10: A commit of N in the same cycle as an accepted byte leaves the fill count at its old value + N - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data (window bytes use bits [7:0]) |
| bus_rdata | output | 32 | Registered host read data |
| tx_valid | output | 1 | A committed byte is presented |
| tx_data | output | 8 | Oldest committed byte |
| tx_ready | input | 1 | Transmitter accepts the presented byte |
| space_avail | output | 1 | Fill count at or below the programmed threshold |

## Verification
A commit or a configuration write takes effect on the edge that samples it. So `tx_valid`, `space_avail` and the fill count change in the cycle after the write strobe, and a register read shows the state from before its own edge one cycle later. Byte transfers are judged by a monitor that sets `tx_ready` at the falling edge and looks at `tx_valid` one time step later. This matches the pair the next rising edge will take. Register reads and flag checks are made only while `tx_ready` is held low, or after the buffer has drained, so that no transfer moves the count between the stimulus and the sample.

// File: rtl/txwin_pkg.sv
package txwin_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CFG  = 2'd3
  } host_sel_e;

  // Space threshold for trigger code n: 2^(n+2) bytes.
  function automatic int trig_level(input int code);
    return 1 << (code + 2);
  endfunction

endpackage

// File: rtl/txwin_host.sv
module txwin_host
  import txwin_pkg::*;
#(
  parameter int BUS_AW    = 12,
  parameter int BUS_DW    = 32,
  parameter int DEPTH_W   = 10,
  parameter int DATA_W    = 8,
  parameter int TRIG_W    = 3,
  parameter int TRIG_RST  = 5,
  parameter int WIN_BASE  = 'h400,
  parameter int CTRL_ADDR = 'h804,
  parameter int CFG_ADDR  = 'h808,
  parameter int CNT_LSB   = 16,
  parameter int CFG_LSB   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  input  logic [DEPTH_W-1:0] fill_cnt,
  input  logic [DEPTH_W-1:0] wr_ptr,
  output logic               win_we,
  output logic [DEPTH_W-1:0] win_off,
  output logic [DATA_W-1:0]  win_byte,
  output logic               commit_en,
  output logic [DEPTH_W-1:0] commit_n,
  output logic [TRIG_W-1:0]  trig_code,
  output logic [BUS_DW-1:0]  bus_rdata
);

  localparam int DEPTH = 1 << DEPTH_W;

  host_sel_e           sel;
  logic [TRIG_W-1:0]   code_q, code_d;
  logic [BUS_DW-1:0]   rdata_q, rdata_d;
  logic                rdata_en;
  logic [BUS_AW-1:0]   rel_addr;

  always_comb begin
    rel_addr = bus_addr - BUS_AW'(WIN_BASE);
    if (bus_addr >= BUS_AW'(WIN_BASE) && bus_addr < BUS_AW'(WIN_BASE + DEPTH))
      sel = SEL_WIN;
    else if (bus_addr == BUS_AW'(CTRL_ADDR))
      sel = SEL_CTRL;
    else if (bus_addr == BUS_AW'(CFG_ADDR))
      sel = SEL_CFG;
    else
      sel = SEL_NONE;
  end

  always_comb begin
    win_we    = bus_wr && (sel == SEL_WIN);
    win_off   = rel_addr[DEPTH_W-1:0];
    win_byte  = bus_wdata[DATA_W-1:0];
    commit_en = bus_wr && (sel == SEL_CTRL);
    commit_n  = bus_wdata[DEPTH_W-1:0];
  end

  always_comb begin
    code_d = code_q;
    if (bus_wr && sel == SEL_CFG)
      code_d = bus_wdata[CFG_LSB +: TRIG_W];
  end

  always_comb begin
    rdata_en = bus_rd;
    rdata_d  = '0;
    case (sel)
      SEL_CTRL: begin
        rdata_d[CNT_LSB +: DEPTH_W] = fill_cnt;
        rdata_d[DEPTH_W-1:0]        = wr_ptr;
      end
      SEL_CFG:  rdata_d[CFG_LSB +: TRIG_W] = code_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= TRIG_W'(TRIG_RST);
      rdata_q <= '0;
    end else begin
      code_q <= code_d;
      if (rdata_en)
        rdata_q <= rdata_d;
    end
  end

  assign trig_code = code_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/txwin_ram.sv
module txwin_ram #(
  parameter int DEPTH_W = 10,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);

  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txwin_track.sv
module txwin_track
  import txwin_pkg::*;
#(
  parameter int DEPTH_W = 10,
  parameter int TRIG_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_en,
  input  logic [DEPTH_W-1:0] commit_n,
  input  logic               pop,
  input  logic [TRIG_W-1:0]  trig_code,
  output logic [DEPTH_W-1:0] wr_ptr,
  output logic [DEPTH_W-1:0] rd_ptr,
  output logic [DEPTH_W-1:0] fill_cnt,
  output logic               nonempty,
  output logic               space_avail
);

  logic [DEPTH_W-1:0] wr_q, wr_d;
  logic [DEPTH_W-1:0] rd_q, rd_d;
  logic [DEPTH_W-1:0] cnt_q, cnt_d;
  logic [DEPTH_W-1:0] add_n;
  logic [DEPTH_W-1:0] sub_n;

  always_comb begin
    add_n = commit_en ? commit_n : '0;
    sub_n = pop ? DEPTH_W'(1) : '0;
    wr_d  = wr_q + add_n;
    rd_d  = rd_q + sub_n;
    cnt_d = cnt_q + add_n - sub_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (commit_en)
        wr_q <= wr_d;
      if (pop)
        rd_q <= rd_d;
      if (commit_en || pop)
        cnt_q <= cnt_d;
    end
  end

  assign wr_ptr      = wr_q;
  assign rd_ptr      = rd_q;
  assign fill_cnt    = cnt_q;
  assign nonempty    = (cnt_q != '0);
  assign space_avail = int'(cnt_q) <= trig_level(int'(trig_code));

endmodule

// File: rtl/txwin_buf.sv
module txwin_buf #(
  parameter int BUS_AW    = 12,
  parameter int BUS_DW    = 32,
  parameter int DEPTH_W   = 10,
  parameter int DATA_W    = 8,
  parameter int TRIG_W    = 3,
  parameter int TRIG_RST  = 5,
  parameter int WIN_BASE  = 'h400,
  parameter int CTRL_ADDR = 'h804,
  parameter int CFG_ADDR  = 'h808,
  parameter int CNT_LSB   = 16,
  parameter int CFG_LSB   = 16,
  parameter int RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              space_avail
);

  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_sync_n;

  // Asynchronous assertion, release through a short flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_SYNC-1];

  logic               win_we;
  logic [DEPTH_W-1:0] win_off;
  logic [DATA_W-1:0]  win_byte;
  logic               commit_en;
  logic [DEPTH_W-1:0] commit_n;
  logic [TRIG_W-1:0]  trig_code;
  logic [DEPTH_W-1:0] wr_ptr, rd_ptr, fill_cnt;
  logic               nonempty;
  logic               pop;
  logic [DEPTH_W-1:0] ram_waddr;

  txwin_host #(
    .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .DEPTH_W(DEPTH_W), .DATA_W(DATA_W),
    .TRIG_W(TRIG_W), .TRIG_RST(TRIG_RST), .WIN_BASE(WIN_BASE),
    .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR), .CNT_LSB(CNT_LSB),
    .CFG_LSB(CFG_LSB)
  ) u_host (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fill_cnt(fill_cnt), .wr_ptr(wr_ptr),
    .win_we(win_we), .win_off(win_off), .win_byte(win_byte),
    .commit_en(commit_en), .commit_n(commit_n), .trig_code(trig_code),
    .bus_rdata(bus_rdata)
  );

  // Window offsets are relative to the commit point.
  assign ram_waddr = wr_ptr + win_off;

  txwin_ram #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(win_we), .waddr(ram_waddr), .wdata(win_byte),
    .raddr(rd_ptr), .rdata(tx_data)
  );

  txwin_track #(.DEPTH_W(DEPTH_W), .TRIG_W(TRIG_W)) u_track (
    .clk(clk), .rst_n(rst_sync_n),
    .commit_en(commit_en), .commit_n(commit_n), .pop(pop),
    .trig_code(trig_code),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill_cnt(fill_cnt),
    .nonempty(nonempty), .space_avail(space_avail)
  );

  assign tx_valid = nonempty;
  assign pop      = tx_valid & tx_ready;

endmodule

// File: rtl/txwin_buf_chk.sv
module txwin_buf_chk #(
  parameter int DEPTH_W = 10,
  parameter int DATA_W  = 8,
  parameter int FILL_MAX = 1020
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [DATA_W-1:0]  tx_data,
  input logic [DEPTH_W-1:0] fill_cnt,
  input logic [DEPTH_W-1:0] wr_ptr,
  input logic               commit_en,
  input logic [DEPTH_W-1:0] commit_n,
  input logic               space_avail
);

  p_valid_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid == (fill_cnt != '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !commit_en |=> fill_cnt == DEPTH_W'($past(fill_cnt) - 1'b1));

  p_commit_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> wr_ptr == DEPTH_W'($past(wr_ptr) + $past(commit_n)));

  p_commit_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && tx_valid && tx_ready |=>
      fill_cnt == DEPTH_W'($past(fill_cnt) + $past(commit_n) - 1'b1));

  p_empty_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt == '0 |-> space_avail);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_cnt) <= FILL_MAX);

endmodule

bind txwin_buf txwin_buf_chk #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .fill_cnt(fill_cnt), .wr_ptr(wr_ptr),
  .commit_en(commit_en), .commit_n(commit_n), .space_avail(space_avail)
);

// File: tb/txwin_buf_tb.sv
module txwin_buf_tb;

  localparam int WIN  = 'h400;
  localparam int CTRL = 'h804;
  localparam int CFG  = 'h808;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        space_avail;

  int nchk = 0, nfail = 0;
  int cyc = 0, mcnt = 0;
  bit ready_en = 0, gap_en = 1, done = 0;
  int exp_wptr = 0;
  logic [7:0] sb_q[$];
  logic [31:0] rd;

  always #4 clk = ~clk;

  txwin_buf u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .space_avail(space_avail)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: sets ready at the falling edge, checks the pair one step later.
  initial forever begin
    @(negedge clk);
    tx_ready = ready_en && (!gap_en || (mcnt % 3) != 2);
    mcnt++;
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (sb_q.size() == 0)
        chk("R3/R6 unexpected byte", int'(tx_data), -1);
      else
        chk("R2/R6/R9 byte order", int'(tx_data), int'(sb_q.pop_front()));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // All tasks start and end one time step after a rising edge.
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bwr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic brd(input int a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = 12'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] pat(input int seed, input int off);
    return 8'(seed * 13 + off * 7 + 1);
  endfunction

  task automatic stage(input int n, input int seed, input bit rev);
    for (int i = 0; i < n; i++) begin
      int off = rev ? n - 1 - i : i;
      bwr(WIN + off, int'(pat(seed, off)));
    end
  endtask

  task automatic commit(input int n, input int seed);
    for (int i = 0; i < n; i++) sb_q.push_back(pat(seed, i));
    bwr(CTRL, n);
    exp_wptr = (exp_wptr + n) % 1024;
  endtask

  task automatic drain();
    ready_en = 1; gap_en = 1;
    for (int i = 0; i < 5000; i++) begin
      if (sb_q.size() == 0 && !tx_valid) break;
      idle(1);
    end
    ready_en = 0;
    idle(2);
    chk("R6 scoreboard empty", sb_q.size(), 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 space_avail", int'(space_avail), 1);
    brd(CTRL, rd);
    chk("R1/R5 ctrl read", int'(rd), 0);
    brd(CFG, rd);
    chk("R1/R7 trig code", int'(rd), 5 << 16);

    // R3 staged bytes invisible, written in descending offset order (R2)
    ready_en = 1;
    stage(4, 1, 1);
    idle(5);
    chk("R3 no valid while staged", int'(tx_valid), 0);
    ready_en = 0;
    idle(2);
    brd(CTRL, rd);
    chk("R3 ctrl unchanged", int'(rd), 0);

    // R4/R5 commit with ready held low
    commit(4, 1);
    chk("R8 valid after commit", int'(tx_valid), 1);
    brd(CTRL, rd);
    chk("R4/R5 fill field", int'(rd[25:16]), 4);
    chk("R4/R5 wptr field", int'(rd[9:0]), exp_wptr);
    chk("R5 spare bits", int'(rd & 32'hFC00_FC00), 0);
    chk("R7 space at 4 of 128", int'(space_avail), 1);
    drain();
    chk("R8 valid low when empty", int'(tx_valid), 0);

    // R7 threshold with code 0 (4 bytes)
    bwr(CFG, 0);
    brd(CFG, rd);
    chk("R7 code readback", int'(rd), 0);
    stage(4, 2, 0);
    commit(4, 2);
    chk("R7 space at 4 of 4", int'(space_avail), 1);
    stage(1, 3, 0);
    commit(1, 3);
    chk("R7 space at 5 of 4", int'(space_avail), 0);
    drain();
    chk("R7 space after drain", int'(space_avail), 1);

    // R10 commit in the same cycle as an accepted byte
    bwr(CFG, 5 << 16);
    stage(3, 4, 0);
    commit(3, 4);
    stage(2, 5, 0);
    gap_en = 0;
    ready_en = 1;
    for (int i = 0; i < 2; i++) sb_q.push_back(pat(5, i));
    exp_wptr = (exp_wptr + 2) % 1024;
    bus_wr = 1'b1; bus_addr = 12'(CTRL); bus_wdata = 32'd2;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    ready_en = 0;
    idle(2);
    brd(CTRL, rd);
    chk("R10 fill after commit+pop", int'(rd[25:16]), 4);
    chk("R10 wptr", int'(rd[9:0]), exp_wptr);
    drain();

    // R9 wrap across the end of storage
    for (int b = 0; b < 4; b++) begin
      stage(300, 10 + b, b[0]);
      commit(300, 10 + b);
      drain();
    end
    brd(CTRL, rd);
    chk("R9 wptr after wrap", int'(rd[9:0]), exp_wptr);
    chk("R9 fill after wrap", int'(rd[25:16]), 0);
    chk("R8 idle at end", int'(tx_valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule